// File: doc/BRIEF.md
# Network Interrupt Moderation Controller

This block gathers interrupt causes from the receive and transmit sides of a network controller and drives one level-sensitive interrupt line to the host. Cause bits are posted into a pending register, and a mask decides which of them may raise the line. A global throttle counter enforces a minimum spacing between successive rising edges of the line. A post marked immediate skips that spacing.

Four delay timers sit beside the pending register. Two belong to the receive direction and two to the transmit direction. One timer in each direction restarts on every packet event. The other runs from the first event of a burst and is not restarted until it has expired. When either timer of a direction runs out, the block pulses a descriptor-writeback request for that direction, posts that direction's fixed cause bit, and cancels both timers of the direction. Timers, the throttle value and the mask are loaded through a small register write port. The host takes the pending causes with a read-and-clear strobe.

Top module: `imc_moderator`

## Requirements
- R1: A post with `post_valid` high ORs `post_cause` into the pending register. The new value appears on `cause_rd_data` after the next clock edge, and earlier pending bits are kept.
- R2: `irq` is high only while some pending bit is also set in the mask. A cause whose mask bit is 0 stays pending and does not raise `irq`.
- R3: A write with `reg_sel`=0 loads the mask from `reg_wdata[CAUSE_W-1:0]`. If this unmasks a pending cause and the throttle is idle, `irq` rises after that edge. If it leaves no enabled cause, `irq` falls after that edge.
- R4: A cycle with `cause_rd` high clears every pending bit that is not posted in that same cycle. With no concurrent post and no timer expiry, `cause_rd_data` reads 0 and `irq` is low after the edge.
- R5: Each rising edge of `irq` loads the throttle counter from the throttle register (`reg_sel`=5). Until that counter expires, a non-immediate post leaves `irq` low. The line rises on the edge at which the counter expires.
- R6: A post with both `post_valid` and `post_now` high raises `irq` after the next edge whenever the posted cause is enabled, even while the throttle counter is running.
- R7: The receive packet timer (`reg_sel`=1) reloads on every `rx_pkt_evt`. After that many ticks with no further event, it gives a one-cycle `rx_wb_req` pulse and sets receive-timer cause bit 7.
- R8: The receive absolute timer (`reg_sel`=2) starts on an `rx_pkt_evt` only while it is idle. Later events do not restart it. On expiry it gives the same `rx_wb_req` pulse and sets cause bit 7.
- R9: The transmit packet timer (`reg_sel`=3) restarts on each `tx_pkt_evt`. The transmit absolute timer (`reg_sel`=4) starts only while idle. Either one on expiry gives a one-cycle `tx_wb_req` pulse and sets transmit-written cause bit 0.
- R10: A delay timer whose register holds 0 is never armed by a packet event and never requests a writeback.
- R11: When either timer of a direction expires, both timers of that direction are cancelled, so one event gives exactly one writeback request.
- R12: Timers and the throttle count in ticks of TICK_NS nanoseconds (default 1024), that is TICK_NS/CLK_NS clock cycles. A value V expires between (V-1) and V ticks after it is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| post_valid | input | 1 | Post the causes on `post_cause` this cycle |
| post_cause | input | CAUSE_W | Cause bits to post |
| post_now | input | 1 | Immediate post that bypasses the throttle |
| rx_pkt_evt | input | 1 | Receive packet event that arms the receive timers |
| tx_pkt_evt | input | 1 | Transmit packet event that arms the transmit timers |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 mask, 1 rx packet, 2 rx absolute, 3 tx packet, 4 tx absolute, 5 throttle |
| reg_wdata | input | TMR_W | Register write data |
| cause_rd | input | 1 | Read-and-clear strobe for the pending causes |
| cause_rd_data | output | CAUSE_W | Current pending causes |
| irq | output | 1 | Interrupt line to the host |
| rx_wb_req | output | 1 | Receive descriptor writeback request pulse |
| tx_wb_req | output | 1 | Transmit descriptor writeback request pulse |

## Verification
Random posts, read-and-clear strobes and mask writes run with the throttle at zero. This pattern tests the pending-accumulation and mask-gating logic against a bench model on every cycle. Directed sequences hold a cause back behind a running throttle and then send an immediate post during that window. These tell apart the timed release from the bypass. The timer sequences send a second packet event in the middle of a countdown. The measured latency then shows whether the timer restarted or kept running, and loading both timers of one direction shows whether the partner was cancelled.

// File: rtl/imc_pkg.sv
package imc_pkg;
    typedef enum logic [2:0] {
        SEL_MASK     = 3'd0,
        SEL_RX_PKT   = 3'd1,
        SEL_RX_ABS   = 3'd2,
        SEL_TX_PKT   = 3'd3,
        SEL_TX_ABS   = 3'd4,
        SEL_THROTTLE = 3'd5
    } reg_sel_e;

    localparam int TIMER_N  = 4;
    localparam int T_RX_PKT = 0;
    localparam int T_RX_ABS = 1;
    localparam int T_TX_PKT = 2;
    localparam int T_TX_ABS = 3;
endpackage

// File: rtl/imc_prescaler.sv
module imc_prescaler #(
    parameter int DIV = 51
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int W = (DIV < 2) ? 1 : $clog2(DIV);

    logic [W-1:0] cnt_d, cnt_q;

    assign tick = (cnt_q == W'(DIV - 1));

    always_comb begin
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/imc_delay_timer.sv
module imc_delay_timer #(
    parameter int CNT_W   = 16,
    parameter bit RESTART = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             evt,
    input  logic             cancel,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             may_load;

    assign expire = tick && (cnt_q == CNT_W'(1));

    always_comb begin
        cnt_d = cnt_q;
        if (cancel)
            cnt_d = '0;
        else if (tick && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        // restarting flavour reloads on any event, absolute flavour only when idle
        may_load = RESTART || (cnt_q == '0) || cancel;
        if (evt && load_val != '0 && may_load)
            cnt_d = load_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/imc_moderator.sv
module imc_moderator #(
    parameter int CAUSE_W    = 8,
    parameter int TMR_W      = 16,
    parameter int TICK_NS    = 1024,
    parameter int CLK_NS     = 20,
    parameter int TXDW_BIT   = 0,
    parameter int RX_TMR_BIT = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               post_valid,
    input  logic [CAUSE_W-1:0] post_cause,
    input  logic               post_now,
    input  logic               rx_pkt_evt,
    input  logic               tx_pkt_evt,
    input  logic               reg_wr_en,
    input  logic [2:0]         reg_sel,
    input  logic [TMR_W-1:0]   reg_wdata,
    input  logic               cause_rd,
    output logic [CAUSE_W-1:0] cause_rd_data,
    output logic               irq,
    output logic               rx_wb_req,
    output logic               tx_wb_req
);
    import imc_pkg::*;

    localparam int RAW_DIV     = TICK_NS / CLK_NS;
    localparam int TICK_CYCLES = (RAW_DIV < 2) ? 2 : RAW_DIV;

    typedef struct packed {
        logic [CAUSE_W-1:0]             pend;
        logic [CAUSE_W-1:0]             mask;
        logic [TIMER_N-1:0][TMR_W-1:0]  dly;
        logic [TMR_W-1:0]               thr_val;
        logic [TMR_W-1:0]               thr_cnt;
        logic                           irq;
        logic                           rx_wb;
        logic                           tx_wb;
    } state_t;

    state_t s_d, s_q;

    logic               tick;
    logic [TIMER_N-1:0] expire;
    logic [TIMER_N-1:0] evt_v;
    logic [TIMER_N-1:0] cancel_v;
    logic               rx_fire, tx_fire;
    logic               thr_expire, allow, enabled;
    logic [CAUSE_W-1:0] new_c;

    imc_prescaler #(.DIV(TICK_CYCLES)) i_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    assign rx_fire = expire[T_RX_PKT] | expire[T_RX_ABS];
    assign tx_fire = expire[T_TX_PKT] | expire[T_TX_ABS];

    for (genvar g = 0; g < TIMER_N; g++) begin : g_tmr
        localparam bit IS_RX = (g == T_RX_PKT) || (g == T_RX_ABS);
        localparam bit RST_K = (g == T_RX_PKT) || (g == T_TX_PKT);

        assign evt_v[g]    = IS_RX ? rx_pkt_evt : tx_pkt_evt;
        assign cancel_v[g] = IS_RX ? rx_fire : tx_fire;

        imc_delay_timer #(.CNT_W(TMR_W), .RESTART(RST_K)) i_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .evt      (evt_v[g]),
            .cancel   (cancel_v[g]),
            .load_val (s_q.dly[g]),
            .expire   (expire[g])
        );
    end

    always_comb begin
        s_d       = s_q;
        s_d.rx_wb = rx_fire;
        s_d.tx_wb = tx_fire;

        new_c = '0;
        if (post_valid) new_c = post_cause;
        if (rx_fire)    new_c[RX_TMR_BIT] = 1'b1;
        if (tx_fire)    new_c[TXDW_BIT]   = 1'b1;
        s_d.pend = (cause_rd ? '0 : s_q.pend) | new_c;

        if (reg_wr_en) begin
            case (reg_sel_e'(reg_sel))
                SEL_MASK:     s_d.mask              = reg_wdata[CAUSE_W-1:0];
                SEL_RX_PKT:   s_d.dly[T_RX_PKT]     = reg_wdata;
                SEL_RX_ABS:   s_d.dly[T_RX_ABS]     = reg_wdata;
                SEL_TX_PKT:   s_d.dly[T_TX_PKT]     = reg_wdata;
                SEL_TX_ABS:   s_d.dly[T_TX_ABS]     = reg_wdata;
                SEL_THROTTLE: s_d.thr_val           = reg_wdata;
                default:      ;
            endcase
        end

        // throttle: release on idle, on the expiring tick, or on an immediate post
        thr_expire = tick && (s_q.thr_cnt == TMR_W'(1));
        allow      = (s_q.thr_cnt == '0) || thr_expire || (post_valid && post_now);
        enabled    = |(s_d.pend & s_d.mask);
        s_d.irq    = enabled && (s_q.irq || allow);

        if (tick && s_q.thr_cnt != '0)
            s_d.thr_cnt = s_q.thr_cnt - 1'b1;
        if (s_d.irq && !s_q.irq)
            s_d.thr_cnt = s_q.thr_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cause_rd_data = s_q.pend;
    assign irq           = s_q.irq;
    assign rx_wb_req     = s_q.rx_wb;
    assign tx_wb_req     = s_q.tx_wb;
endmodule

// File: rtl/imc_moderator_chk.sv
module imc_moderator_chk #(
    parameter int CAUSE_W    = 8,
    parameter int TMR_W      = 16,
    parameter int TXDW_BIT   = 0,
    parameter int RX_TMR_BIT = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic               post_valid,
    input logic               post_now,
    input logic               cause_rd,
    input logic [CAUSE_W-1:0] cause_rd_data,
    input logic               irq,
    input logic               rx_wb_req,
    input logic               tx_wb_req,
    input logic [CAUSE_W-1:0] mask,
    input logic [TMR_W-1:0]   thr_cnt,
    input logic [TMR_W-1:0]   thr_val,
    input logic               tick
);
    localparam logic [CAUSE_W-1:0] TMR_BITS =
        (CAUSE_W'(1) << TXDW_BIT) | (CAUSE_W'(1) << RX_TMR_BIT);

    p_irq_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((cause_rd_data & mask) != '0));

    p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_rd && !post_valid) |=> ((cause_rd_data & ~TMR_BITS) == '0));

    p_rise_allowed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past((thr_cnt == '0) || (tick && thr_cnt == TMR_W'(1))
                             || (post_valid && post_now)));

    p_thr_reload_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (thr_cnt == $past(thr_val)));

    p_rx_wb_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_wb_req |-> cause_rd_data[RX_TMR_BIT]);

    p_tx_wb_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wb_req |-> cause_rd_data[TXDW_BIT]);
endmodule

bind imc_moderator imc_moderator_chk #(
    .CAUSE_W    (CAUSE_W),
    .TMR_W      (TMR_W),
    .TXDW_BIT   (TXDW_BIT),
    .RX_TMR_BIT (RX_TMR_BIT)
) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .post_valid    (post_valid),
    .post_now      (post_now),
    .cause_rd      (cause_rd),
    .cause_rd_data (cause_rd_data),
    .irq           (irq),
    .rx_wb_req     (rx_wb_req),
    .tx_wb_req     (tx_wb_req),
    .mask          (s_q.mask),
    .thr_cnt       (s_q.thr_cnt),
    .thr_val       (s_q.thr_val),
    .tick          (tick)
);

// File: tb/test_imc_moderator.sv
module test_imc_moderator;
    localparam int CW = 8;
    localparam int TW = 16;
    localparam int P  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          post_valid = 1'b0;
    logic [CW-1:0] post_cause = '0;
    logic          post_now = 1'b0;
    logic          rx_pkt_evt = 1'b0;
    logic          tx_pkt_evt = 1'b0;
    logic          reg_wr_en = 1'b0;
    logic [2:0]    reg_sel = '0;
    logic [TW-1:0] reg_wdata = '0;
    logic          cause_rd = 1'b0;
    logic [CW-1:0] cause_rd_data;
    logic          irq, rx_wb_req, tx_wb_req;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int rx_pulses = 0;
    int tx_pulses = 0;

    imc_moderator #(.CAUSE_W(CW), .TMR_W(TW), .TICK_NS(80), .CLK_NS(20)) i_imc_moderator (
        .clk(clk), .rst_n(rst_n), .post_valid(post_valid), .post_cause(post_cause),
        .post_now(post_now), .rx_pkt_evt(rx_pkt_evt), .tx_pkt_evt(tx_pkt_evt),
        .reg_wr_en(reg_wr_en), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .cause_rd(cause_rd), .cause_rd_data(cause_rd_data), .irq(irq),
        .rx_wb_req(rx_wb_req), .tx_wb_req(tx_wb_req)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rx_wb_req) rx_pulses <= rx_pulses + 1;
        if (tx_wb_req) tx_pulses <= tx_pulses + 1;
        if (cyc > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    function automatic logic [CW-1:0] model_pend(logic [CW-1:0] pend, logic pv,
                                                 logic [CW-1:0] c, logic rd);
        return (rd ? '0 : pend) | (pv ? c : '0);
    endfunction

    function automatic logic model_irq(logic [CW-1:0] pend, logic [CW-1:0] msk);
        return |(pend & msk);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_rng(string req, int act, int lo, int hi);
        checks = checks + 1;
        if (act < lo || act > hi) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [2:0] sel, logic [TW-1:0] d);
        reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = d;
        step();
        reg_wr_en = 1'b0;
    endtask

    task automatic post(logic [CW-1:0] c, logic now);
        post_valid = 1'b1; post_cause = c; post_now = now;
        step();
        post_valid = 1'b0; post_cause = '0; post_now = 1'b0;
    endtask

    task automatic rd_clear();
        cause_rd = 1'b1;
        step();
        cause_rd = 1'b0;
    endtask

    task automatic wait_rx(output int n);
        n = 0;
        do begin step(); n++; end while (!rx_wb_req && n < 200);
    endtask

    task automatic wait_tx(output int n);
        n = 0;
        do begin step(); n++; end while (!tx_wb_req && n < 200);
    endtask

    initial begin
        int n;
        int base;
        logic [CW-1:0] pend_exp;
        logic [CW-1:0] mask_exp;

        void'($urandom(32'd4242));
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R4 reset pending", cause_rd_data, 0);
        chk("R2 reset irq", irq, 0);
        chk("R7 reset rx_wb", rx_wb_req, 0);

        // R1/R2: post and accumulate with all causes enabled
        wr(3'd0, 16'h00FF);
        wr(3'd5, 16'd0);
        post(8'h02, 1'b0);
        chk("R1 post recorded", cause_rd_data, 8'h02);
        chk("R2 irq enabled cause", irq, 1);
        post(8'h04, 1'b0);
        chk("R1 accumulate", cause_rd_data, 8'h06);
        rd_clear();
        chk("R4 read clears", cause_rd_data, 0);
        chk("R4 read drops irq", irq, 0);

        // R2/R3: masking
        wr(3'd0, 16'h0000);
        post(8'h08, 1'b0);
        chk("R2 masked stays pending", cause_rd_data, 8'h08);
        chk("R2 masked no irq", irq, 0);
        wr(3'd0, 16'h0008);
        chk("R3 unmask raises irq", irq, 1);
        wr(3'd0, 16'h0000);
        chk("R3 mask off drops irq", irq, 0);
        rd_clear();

        // R5/R12: throttle holds then releases
        wr(3'd0, 16'h00FF);
        wr(3'd5, 16'd5);
        post(8'h02, 1'b0);
        chk("R5 first rise", irq, 1);
        rd_clear();
        chk("R4 clear during throttle", irq, 0);
        post(8'h04, 1'b0);
        chk("R5 throttled post held", irq, 0);
        n = 2;
        while (!irq && n < 200) begin step(); n++; end
        chk_rng("R5 R12 throttle release delay", n, 4*P+1, 5*P);

        // R6: immediate bypass
        rd_clear();
        post(8'h10, 1'b1);
        chk("R6 immediate bypass", irq, 1);
        rd_clear();
        wr(3'd5, 16'd0);
        repeat (30) step();

        // R7: packet timer restarts on every event
        wr(3'd1, 16'd3);
        wr(3'd2, 16'd0);
        rx_pkt_evt = 1'b1; step(); rx_pkt_evt = 1'b0;
        wait_rx(n);
        chk_rng("R7 R12 rx packet delay", n, 2*P+1, 3*P);
        chk("R7 rx cause bit7", cause_rd_data[7], 1);
        step();
        chk("R7 wb single cycle", rx_wb_req, 0);
        rx_pkt_evt = 1'b1; step(); rx_pkt_evt = 1'b0;
        repeat (5) step();
        rx_pkt_evt = 1'b1; step(); rx_pkt_evt = 1'b0;
        wait_rx(n);
        chk_rng("R7 restart on second event", n, 2*P+1, 3*P);

        // R8: absolute timer not restarted
        wr(3'd1, 16'd0);
        wr(3'd2, 16'd3);
        rx_pkt_evt = 1'b1; step(); rx_pkt_evt = 1'b0;
        repeat (5) step();
        rx_pkt_evt = 1'b1; step(); rx_pkt_evt = 1'b0;
        wait_rx(n);
        chk_rng("R8 absolute keeps running", n, 2*P+1-6, 3*P-6);

        // R11: one writeback per event when both timers armed
        wr(3'd1, 16'd2);
        wr(3'd2, 16'd4);
        repeat (3) step();
        base = rx_pulses;
        rx_pkt_evt = 1'b1; step(); rx_pkt_evt = 1'b0;
        repeat (30) step();
        chk("R11 single rx writeback", rx_pulses - base, 1);

        // R9: transmit timers
        rd_clear();
        wr(3'd3, 16'd2);
        wr(3'd4, 16'd0);
        tx_pkt_evt = 1'b1; step(); tx_pkt_evt = 1'b0;
        wait_tx(n);
        chk_rng("R9 tx packet delay", n, P+1, 2*P);
        chk("R9 tx cause bit0", cause_rd_data[0], 1);
        wr(3'd3, 16'd0);
        wr(3'd4, 16'd2);
        tx_pkt_evt = 1'b1; step(); tx_pkt_evt = 1'b0;
        wait_tx(n);
        chk_rng("R9 tx absolute delay", n, P+1, 2*P);

        // R10: zero disables
        wr(3'd4, 16'd0);
        rd_clear();
        base = tx_pulses;
        tx_pkt_evt = 1'b1; step(); tx_pkt_evt = 1'b0;
        repeat (30) step();
        chk("R10 zero timer no writeback", tx_pulses - base, 0);
        chk("R10 zero timer no cause", cause_rd_data[0], 0);

        // random traffic with throttle off and timers off
        wr(3'd1, 16'd0);
        wr(3'd2, 16'd0);
        wr(3'd0, 16'h00FF);
        rd_clear();
        repeat (30) step();
        pend_exp = cause_rd_data;
        mask_exp = 8'hFF;
        chk("R4 pending idle before random", pend_exp, 0);
        for (int i = 0; i < 300; i++) begin
            logic          pv, rd, mw, nw;
            logic [CW-1:0] c, m;
            pv = ($urandom % 3) == 0;
            c  = CW'($urandom) & 8'h7E;
            nw = $urandom % 2;
            rd = ($urandom % 8) == 0;
            mw = ($urandom % 10) == 0;
            m  = CW'($urandom);
            if (i < 4) begin pv = 1'b1; c = 8'h7E; end
            post_valid = pv; post_cause = c; post_now = nw; cause_rd = rd;
            reg_wr_en = mw; reg_sel = 3'd0; reg_wdata = {8'h00, m};
            step();
            post_valid = 1'b0; cause_rd = 1'b0; reg_wr_en = 1'b0; post_now = 1'b0;
            pend_exp = model_pend(pend_exp, pv, c, rd);
            if (mw) mask_exp = m;
            chk("R1 random pending", cause_rd_data, pend_exp);
            chk("R2 random irq", irq, model_irq(pend_exp, mask_exp));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule